// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Mailbox

This block lets two processors, each running on its own unrelated clock, exchange 32-bit words and doorbell signals. Each processor sees its own small register window: a plain memory-mapped port with an address, write data, read data and a write strobe and a read strobe. Each side also has one level interrupt output. Side A and side B use identical register maps. A word or flag written on one side is carried into the other side's clock domain before it becomes visible there.

Each side owns four outgoing data channels, which appear as four incoming channels on the far side. Every channel uses a full/empty handshake. The sender's empty bit returns only after the far side has read the word. Each side can also ring two kinds of doorbell toward the far side. A plain doorbell simply sets a pending bit there. An acknowledged doorbell stays pending until the far software clears it, and the sender can watch for that clear. A single reset request lets one side wipe the messaging state the other side holds. Every crossing carries a toggle through a two-flop synchroniser, and each side's reset input is asserted asynchronously and released on that side's own clock.

Top module: `mbox_unit`

## Requirements
- R1: After reset, each side's status word (word address 8) reads 0x0000000F, meaning all four outgoing channels are empty. The enable register (address 10) and every data register read 0, and both interrupt outputs are low.
- R2: A write to word address ch (0 to 3) on one side is handed to the far side. There, status bit 4+ch is set and address 4+ch returns the word. On the sender, status bit ch (empty) stays clear until the far side reads address 4+ch, and then it returns to 1. Reading address ch on the sender returns the last word it accepted. This works in both directions.
- R3: A write to an outgoing channel whose empty bit is clear is dropped, and the held word is kept. The write also sets sticky status bit 20+ch, which is cleared by writing 1 to that bit at address 8.
- R4: A side's interrupt goes high while status bit 4+ch (incoming full) is set and enable bit 4+ch is set. It drops in the cycle after the full word has been read.
- R5: A side's interrupt goes high while status bit ch (outgoing empty) is set and enable bit ch is set. No interrupt appears while every enabled source is clear.
- R6: Writing a mask to bits 3:0 of address 9 sets the same mask in the far side's plain-doorbell pending bits, which are status bits 11:8. Those bits raise an interrupt when enable bits 11:8 are set, and writing 1 to them at address 8 clears them.
- R7: Writing bit 4+ch of address 9 sets the sender's busy bit 16+ch and the far side's pending bit 12+ch. The far side clears the pending bit by writing 1 to bit 12+ch at address 8. The sender's busy bit then clears.
- R8: Ringing an acknowledged doorbell whose busy bit is still set has no effect, and the far pending bit stays set.
- R9: Writing bit 8 of address 9 sets the requester's status bit 24. The far side then clears its incoming full bits, its plain pending bits and its acknowledged-doorbell pending bits. After that, the requester's bit 24, its busy bits and its empty bits all settle back to idle, and later transfers work normally.
- R10: The enable register at address 10 is 16 bits wide. It reads back what was written, and bits 31:16 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aClk | input | 1 | Side A clock |
| aRstN | input | 1 | Side A reset, active low, asynchronous assert |
| aAddr | input | 4 | Side A word address |
| aWrData | input | 32 | Side A write data |
| aWrEn | input | 1 | Side A write strobe |
| aRdEn | input | 1 | Side A read strobe (pops incoming words) |
| aRdData | output | 32 | Side A read data, combinational on aAddr |
| aIrq | output | 1 | Side A interrupt |
| bClk | input | 1 | Side B clock |
| bRstN | input | 1 | Side B reset, active low, asynchronous assert |
| bAddr | input | 4 | Side B word address |
| bWrData | input | 32 | Side B write data |
| bWrEn | input | 1 | Side B write strobe |
| bRdEn | input | 1 | Side B read strobe (pops incoming words) |
| bRdData | output | 32 | Side B read data, combinational on bAddr |
| bIrq | output | 1 | Side B interrupt |

## Verification
The bench uses the default build: four channels per direction and 32-bit words. It runs the two sides from unrelated 4 ns and 6 ns clocks, so every handshake crosses at a changing phase. With only four channels, the bench can sweep every channel in both directions with several arithmetic data patterns. It can also ring all fifteen non-zero plain-doorbell masks from each side and walk every acknowledged doorbell. It also runs the overrun case, the ignored re-ring and a reset request with traffic in flight.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int MB_CH = 4;
  parameter int MB_DW = 32;
  parameter int MB_AW = 4;

  // word addresses
  localparam int ADDR_TX   = 0;
  localparam int ADDR_RX   = MB_CH;
  localparam int ADDR_STAT = 2 * MB_CH;
  localparam int ADDR_RING = 2 * MB_CH + 1;
  localparam int ADDR_IEN  = 2 * MB_CH + 2;

  // status word field offsets
  localparam int FLD_DB  = 2 * MB_CH;
  localparam int FLD_SDB = 3 * MB_CH;
  localparam int FLD_OVR = 5 * MB_CH;

  // ring word field offsets
  localparam int RING_DB  = 0;
  localparam int RING_SDB = MB_CH;
  localparam int RING_RST = 2 * MB_CH;

  localparam int IEN_W = 4 * MB_CH;

  typedef struct packed {
    logic [MB_CH-1:0] txLoad;
    logic [MB_CH-1:0] ovrSet;
    logic [MB_CH-1:0] rxPop;
    logic [MB_CH-1:0] dbRing;
    logic [MB_CH-1:0] sdbRing;
    logic [MB_CH-1:0] dbClr;
    logic [MB_CH-1:0] sdbAck;
    logic [MB_CH-1:0] ovrClr;
    logic             rstReq;
    logic             enWr;
  } strobe_t;

  typedef struct packed {
    logic [MB_CH-1:0] txEmpty;
    logic [MB_CH-1:0] rxFull;
    logic [MB_CH-1:0] dbPend;
    logic [MB_CH-1:0] sdbPend;
    logic [MB_CH-1:0] sdbBusy;
    logic             rstBusy;
  } status_t;

  // every toggle one side sends across to the other
  typedef struct packed {
    logic [MB_CH-1:0] txTog;
    logic [MB_CH-1:0] ackTog;
    logic [MB_CH-1:0] dbTog;
    logic [MB_CH-1:0] sdbTog;
    logic [MB_CH-1:0] sdbAckTog;
    logic             rstTog;
    logic             rstAckTog;
  } tog_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic [MB_AW-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [MB_DW-1:0] wrData,
  input  status_t          stat,
  output strobe_t          strb
);
  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  always_comb begin
    strb = '0;
    for (int i = 0; i < MB_CH; i++) begin
      if (wrEn && addr == MB_AW'(ADDR_TX + i)) begin
        if (stat.txEmpty[i]) strb.txLoad[i] = 1'b1;
        else                 strb.ovrSet[i] = 1'b1;
      end
      if (rdEn && addr == MB_AW'(ADDR_RX + i)) strb.rxPop[i] = 1'b1;
    end
    if (wrEn && addr == MB_AW'(ADDR_RING)) begin
      strb.dbRing  = wrData[RING_DB +: MB_CH];
      strb.sdbRing = wrData[RING_SDB +: MB_CH] & ~stat.sdbBusy;
      strb.rstReq  = wrData[RING_RST] & ~stat.rstBusy;
    end
    if (wrEn && addr == MB_AW'(ADDR_STAT)) begin
      strb.dbClr  = wrData[FLD_DB +: MB_CH];
      strb.sdbAck = wrData[FLD_SDB +: MB_CH];
      strb.ovrClr = wrData[FLD_OVR +: MB_CH];
    end
    strb.enWr = wrEn && addr == MB_AW'(ADDR_IEN);
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [MB_AW-1:0]            addr,
  input  logic [MB_DW-1:0]            wrData,
  input  strobe_t                     strb,
  input  tog_t                        farTog,
  input  logic [MB_CH-1:0][MB_DW-1:0] farTxData,
  output tog_t                        myTog,
  output logic [MB_CH-1:0][MB_DW-1:0] myTxData,
  output status_t                     stat,
  output logic [MB_DW-1:0]            rdData,
  output logic                        irq
);
  tog_t fs;
  tog_t tog;
  logic [MB_CH-1:0] prevTx, prevDb, prevSdb;
  logic             prevRst;
  logic [MB_CH-1:0][MB_DW-1:0] txData, rxData;
  logic [MB_CH-1:0] dbPend, ovr;
  logic [IEN_W-1:0] ien;
  logic [MB_CH-1:0] txArrive, dbArrive, rxFull, sdbPend;
  logic             rstArrive;
  logic [MB_DW-1:0] statWord;
  logic [IEN_W-1:0] pendVec;

  mbox_sync #(.W($bits(tog_t))) uTogSync (
    .clk(clk), .rstN(rstN), .d(farTog), .q(fs)
  );

  assign txArrive  = fs.txTog ^ prevTx;
  assign dbArrive  = fs.dbTog ^ prevDb;
  assign rstArrive = fs.rstTog ^ prevRst;
  assign rxFull    = prevTx ^ tog.ackTog;
  assign sdbPend   = prevSdb ^ tog.sdbAckTog;

  always_comb begin
    stat.txEmpty = ~(tog.txTog ^ fs.ackTog);
    stat.rxFull  = rxFull;
    stat.dbPend  = dbPend;
    stat.sdbPend = sdbPend;
    stat.sdbBusy = tog.sdbTog ^ fs.sdbAckTog;
    stat.rstBusy = tog.rstTog ^ fs.rstAckTog;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog     <= '0;
      prevTx  <= '0;
      prevDb  <= '0;
      prevSdb <= '0;
      prevRst <= 1'b0;
      txData  <= '0;
      rxData  <= '0;
      dbPend  <= '0;
      ovr     <= '0;
      ien     <= '0;
    end else begin
      prevTx  <= fs.txTog;
      prevDb  <= fs.dbTog;
      prevSdb <= fs.sdbTog;
      prevRst <= fs.rstTog;
      tog.txTog  <= tog.txTog ^ strb.txLoad;
      tog.dbTog  <= tog.dbTog ^ strb.dbRing;
      tog.sdbTog <= tog.sdbTog ^ strb.sdbRing;
      if (strb.rstReq) tog.rstTog <= ~tog.rstTog;
      for (int i = 0; i < MB_CH; i++) begin
        if (strb.txLoad[i]) txData[i] <= wrData;
        if (txArrive[i])    rxData[i] <= farTxData[i];
      end
      ovr <= (ovr & ~strb.ovrClr) | strb.ovrSet;
      if (strb.enWr) ien <= wrData[IEN_W-1:0];
      if (rstArrive) begin
        tog.ackTog    <= fs.txTog;
        tog.sdbAckTog <= fs.sdbTog;
        tog.rstAckTog <= fs.rstTog;
        dbPend        <= '0;
      end else begin
        tog.ackTog    <= tog.ackTog ^ (strb.rxPop & rxFull);
        tog.sdbAckTog <= tog.sdbAckTog ^ (strb.sdbAck & sdbPend);
        dbPend        <= (dbPend & ~strb.dbClr) | dbArrive;
      end
    end
  end

  assign myTog    = tog;
  assign myTxData = txData;
  assign statWord = MB_DW'({stat.rstBusy, ovr, stat.sdbBusy, sdbPend, dbPend, rxFull, stat.txEmpty});
  assign pendVec  = {sdbPend, dbPend, rxFull, stat.txEmpty};
  assign irq      = |(pendVec & ien);

  always_comb begin
    rdData = '0;
    for (int i = 0; i < MB_CH; i++) begin
      if (addr == MB_AW'(ADDR_TX + i)) rdData = txData[i];
      if (addr == MB_AW'(ADDR_RX + i)) rdData = rxData[i];
    end
    if (addr == MB_AW'(ADDR_STAT)) rdData = statWord;
    if (addr == MB_AW'(ADDR_IEN))  rdData = MB_DW'(ien);
  end
endmodule

// File: rtl/mbox_unit.sv
module mbox_unit
  import mbox_pkg::*;
(
  input  logic             aClk,
  input  logic             aRstN,
  input  logic [MB_AW-1:0] aAddr,
  input  logic [MB_DW-1:0] aWrData,
  input  logic             aWrEn,
  input  logic             aRdEn,
  output logic [MB_DW-1:0] aRdData,
  output logic             aIrq,
  input  logic             bClk,
  input  logic             bRstN,
  input  logic [MB_AW-1:0] bAddr,
  input  logic [MB_DW-1:0] bWrData,
  input  logic             bWrEn,
  input  logic             bRdEn,
  output logic [MB_DW-1:0] bRdData,
  output logic             bIrq
);
  logic clkV [2];
  logic rstInN [2];
  logic rstN [2];
  logic wrEnV [2];
  logic rdEnV [2];
  logic irqV [2];
  logic [MB_AW-1:0] addrV [2];
  logic [MB_DW-1:0] wrDataV [2];
  logic [MB_DW-1:0] rdDataV [2];
  strobe_t strb [2];
  status_t stat [2];
  tog_t    togV [2];
  logic [MB_CH-1:0][MB_DW-1:0] txDataV [2];

  assign clkV[0] = aClk;     assign clkV[1] = bClk;
  assign rstInN[0] = aRstN;  assign rstInN[1] = bRstN;
  assign addrV[0] = aAddr;   assign addrV[1] = bAddr;
  assign wrDataV[0] = aWrData; assign wrDataV[1] = bWrData;
  assign wrEnV[0] = aWrEn;   assign wrEnV[1] = bWrEn;
  assign rdEnV[0] = aRdEn;   assign rdEnV[1] = bRdEn;
  assign aRdData = rdDataV[0]; assign bRdData = rdDataV[1];
  assign aIrq = irqV[0];     assign bIrq = irqV[1];

  for (genvar s = 0; s < 2; s++) begin : gSide
    mbox_sync #(.W(1)) uRstSync (
      .clk(clkV[s]), .rstN(rstInN[s]), .d(1'b1), .q(rstN[s])
    );

    mbox_ctrl uCtrl (
      .addr(addrV[s]), .wrEn(wrEnV[s]), .rdEn(rdEnV[s]),
      .wrData(wrDataV[s]), .stat(stat[s]), .strb(strb[s])
    );

    mbox_datapath uData (
      .clk(clkV[s]), .rstN(rstN[s]), .addr(addrV[s]), .wrData(wrDataV[s]),
      .strb(strb[s]), .farTog(togV[1-s]), .farTxData(txDataV[1-s]),
      .myTog(togV[s]), .myTxData(txDataV[s]), .stat(stat[s]),
      .rdData(rdDataV[s]), .irq(irqV[s])
    );
  end
endmodule

// File: rtl/mbox_unit_chk.sv
module mbox_unit_chk
  import mbox_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [MB_CH-1:0] txLoad,
  input logic [MB_CH-1:0] rxPop,
  input logic [MB_CH-1:0] sdbRing,
  input logic             rstReq,
  input status_t          stat,
  input logic             irq
);
  assert_load_needs_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    (txLoad & ~stat.txEmpty) == '0);

  assert_load_makes_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|txLoad) |=> ((stat.txEmpty & $past(txLoad)) == '0));

  assert_pop_empties_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|(rxPop & stat.rxFull)) |=> ((stat.rxFull & $past(rxPop)) == '0));

  assert_busy_ring_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sdbRing & stat.sdbBusy) == '0);

  assert_rst_req_marks_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> stat.rstBusy);

  assert_irq_needs_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((stat.txEmpty | stat.rxFull | stat.dbPend | stat.sdbPend) == '0) |-> !irq);
endmodule

bind mbox_unit mbox_unit_chk chkA (
  .clk(clkV[0]), .rstN(rstN[0]), .txLoad(strb[0].txLoad), .rxPop(strb[0].rxPop),
  .sdbRing(strb[0].sdbRing), .rstReq(strb[0].rstReq), .stat(stat[0]), .irq(irqV[0])
);

bind mbox_unit mbox_unit_chk chkB (
  .clk(clkV[1]), .rstN(rstN[1]), .txLoad(strb[1].txLoad), .rxPop(strb[1].rxPop),
  .sdbRing(strb[1].sdbRing), .rstReq(strb[1].rstReq), .stat(stat[1]), .irq(irqV[1])
);

// File: tb/mbox_unit_test.sv
module mbox_unit_test;
  logic aClk = 0, bClk = 0, aRstN = 0, bRstN = 0;
  logic [3:0] aAddr = 0, bAddr = 0;
  logic [31:0] aWrData = 0, bWrData = 0;
  logic aWrEn = 0, bWrEn = 0, aRdEn = 0, bRdEn = 0;
  logic [31:0] aRdData, bRdData;
  logic aIrq, bIrq;
  int compared = 0, mismatched = 0;

  always #2 aClk = ~aClk;
  always #3 bClk = ~bClk;

  mbox_unit uut (
    .aClk(aClk), .aRstN(aRstN), .aAddr(aAddr), .aWrData(aWrData), .aWrEn(aWrEn),
    .aRdEn(aRdEn), .aRdData(aRdData), .aIrq(aIrq),
    .bClk(bClk), .bRstN(bRstN), .bAddr(bAddr), .bWrData(bWrData), .bWrEn(bWrEn),
    .bRdEn(bRdEn), .bRdData(bRdData), .bIrq(bIrq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWr(input int s, input int addr, input logic [31:0] d);
    if (s == 0) begin
      @(negedge aClk); aAddr = 4'(addr); aWrData = d; aWrEn = 1;
      @(negedge aClk); aWrEn = 0;
    end else begin
      @(negedge bClk); bAddr = 4'(addr); bWrData = d; bWrEn = 1;
      @(negedge bClk); bWrEn = 0;
    end
  endtask

  task automatic busRd(input int s, input int addr, output logic [31:0] d);
    if (s == 0) begin
      @(negedge aClk); aAddr = 4'(addr); aRdEn = 1; #1 d = aRdData;
      @(negedge aClk); aRdEn = 0;
    end else begin
      @(negedge bClk); bAddr = 4'(addr); bRdEn = 1; #1 d = bRdData;
      @(negedge bClk); bRdEn = 0;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge bClk);
  endtask

  function automatic logic irqOf(input int s);
    return (s == 0) ? aIrq : bIrq;
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge bClk);
    aRstN = 1; bRstN = 1;
    repeat (6) @(negedge bClk);

    // R1 reset state
    for (int s = 0; s < 2; s++) begin
      busRd(s, 8, v);  check("R1 status", v, 32'h0000000F);
      busRd(s, 10, v); check("R1 enable", v, 32'h0);
      busRd(s, 0, v);  check("R1 tx data", v, 32'h0);
      busRd(s, 4, v);  check("R1 rx data", v, 32'h0);
      check("R1 irq", {31'b0, irqOf(s)}, 32'h0);
    end

    // R10 enable register width
    busWr(0, 10, 32'h12345678); busRd(0, 10, v); check("R10 readback", v, 32'h00005678);
    busWr(1, 10, 32'hFFFFA5C3); busRd(1, 10, v); check("R10 readback", v, 32'h0000A5C3);
    busWr(0, 10, 0); busWr(1, 10, 0);

    // R2 sweep over channels, directions and patterns
    for (int s = 0; s < 2; s++)
      for (int ch = 0; ch < 4; ch++)
        for (int k = 0; k < 3; k++) begin
          logic [31:0] val;
          val = (32'h9E3779B9 * (s * 16 + ch * 4 + k + 1)) ^ (32'(ch) << 28);
          busWr(s, ch, val);
          busRd(s, 8, v); check("R2 sender busy", v, 32'hF & ~(32'h1 << ch));
          busRd(s, ch, v); check("R2 tx readback", v, val);
          settle();
          busRd(1 - s, 8, v); check("R2 far full", v, 32'hF | (32'h10 << ch));
          busRd(1 - s, 4 + ch, v); check("R2 far data", v, val);
          settle();
          busRd(s, 8, v); check("R2 sender empty", v, 32'hF);
          busRd(1 - s, 8, v); check("R2 far drained", v, 32'hF);
        end

    // R3 overrun
    busWr(0, 1, 32'hCAFE0001);
    busWr(0, 1, 32'hBAD00002);
    busRd(0, 8, v); check("R3 overrun flag", v, 32'h0020000D);
    busRd(0, 1, v); check("R3 held word", v, 32'hCAFE0001);
    settle();
    busRd(1, 5, v); check("R3 far word", v, 32'hCAFE0001);
    busWr(0, 8, 32'h00200000);
    settle();
    busRd(0, 8, v); check("R3 overrun cleared", v, 32'h0000000F);

    // R4 rx-full interrupt
    busWr(1, 10, 32'h000000F0);
    busWr(0, 2, 32'h00C0FFEE);
    settle();
    check("R4 irq on full", {31'b0, bIrq}, 32'h1);
    busRd(1, 6, v); check("R4 data", v, 32'h00C0FFEE);
    check("R4 irq after read", {31'b0, bIrq}, 32'h0);
    busWr(1, 10, 0);

    // R5 tx-empty interrupt
    settle();
    busWr(0, 10, 32'h00000001);
    check("R5 irq empty", {31'b0, aIrq}, 32'h1);
    busWr(0, 0, 32'h55AA55AA);
    check("R5 irq busy", {31'b0, aIrq}, 32'h0);
    settle();
    busRd(1, 4, v); check("R5 data", v, 32'h55AA55AA);
    settle();
    check("R5 irq returns", {31'b0, aIrq}, 32'h1);
    busWr(0, 10, 0);

    // R6 plain doorbell masks
    for (int s = 0; s < 2; s++) begin
      busWr(1 - s, 10, 32'h00000F00);
      for (int m = 1; m < 16; m++) begin
        busWr(s, 9, 32'(m));
        settle();
        busRd(1 - s, 8, v); check("R6 pending", (v >> 8) & 32'hF, 32'(m));
        check("R6 irq", {31'b0, irqOf(1 - s)}, 32'h1);
        busWr(1 - s, 8, 32'(m) << 8);
        busRd(1 - s, 8, v); check("R6 cleared", v, 32'h0000000F);
        check("R6 irq cleared", {31'b0, irqOf(1 - s)}, 32'h0);
      end
      busWr(1 - s, 10, 0);
    end

    // R7 acknowledged doorbells
    for (int s = 0; s < 2; s++)
      for (int ch = 0; ch < 4; ch++) begin
        busWr(s, 9, 32'h10 << ch);
        busRd(s, 8, v); check("R7 busy", (v >> 16) & 32'hF, 32'h1 << ch);
        settle();
        busRd(1 - s, 8, v); check("R7 far pending", (v >> 12) & 32'hF, 32'h1 << ch);
        busWr(1 - s, 8, 32'h1000 << ch);
        settle();
        busRd(s, 8, v); check("R7 busy released", v, 32'h0000000F);
        busRd(1 - s, 8, v); check("R7 pending cleared", v, 32'h0000000F);
      end

    // R8 re-ring while busy is ignored
    busWr(0, 9, 32'h10);
    settle();
    busWr(0, 9, 32'h10);
    settle();
    busRd(1, 8, v); check("R8 still pending", (v >> 12) & 32'hF, 32'h1);
    busRd(0, 8, v); check("R8 still busy", (v >> 16) & 32'hF, 32'h1);
    busWr(1, 8, 32'h1000);
    settle();
    busRd(0, 8, v); check("R8 released", v, 32'h0000000F);

    // R9 reset request with traffic in flight
    busWr(0, 3, 32'h0BADF00D);
    busWr(0, 9, 32'h25);
    settle();
    busRd(1, 8, v); check("R9 far loaded", v, 32'h0000258F);
    busWr(0, 9, 32'h100);
    busRd(0, 8, v); check("R9 request flag", (v >> 24) & 32'h1, 32'h1);
    settle();
    busRd(1, 8, v); check("R9 far wiped", v, 32'h0000000F);
    busRd(0, 8, v); check("R9 requester idle", v, 32'h0000000F);
    busWr(0, 3, 32'h600DCAFE);
    settle();
    busRd(1, 7, v); check("R9 transfer after wipe", v, 32'h600DCAFE);

    finishRun();
  end
endmodule